// File: doc/BRIEF.md
# Mixed Strict/Weighted Egress Queue Scheduler

This block picks, for each egress channel, which one of eight QoS queues may send next. Each channel has a 3-bit scheduling mode. The mode splits the eight queues into a strict-priority group and a weighted group. The weighted group always occupies the low queue indices, from 0 upward. The strict group takes the remaining high indices, and within it a higher index has higher priority. Weighted queues share the channel by a credit counter: a queue keeps the grant for as many decisions as its 16-bit weight, and then the turn passes to the next waiting weighted queue.

A queue takes part only when its "has packet" flag is set and its close bit is clear. The channel holds one grant at a time and presents it on its outputs. A pulse on the channel's dequeue input consumes the grant, and the next decision is made on that clock edge. Modes and weights are written through two side ports. Reset brings every channel to all-strict operation with every weight zero.

Top module: `esch_top`

## Requirements
- R1: After reset every channel is in mode 1 (all strict) with all weights zero, and no grant is valid while no queue is eligible.
- R2: With strict queues eligible, the grant goes to the eligible strict queue with the highest index.
- R3: A queue whose close bit is set, or whose packet flag is clear, is never shown as granted. Clearing its close bit makes it eligible again.
- R4: The number of weighted queues is set by the mode code: 0 gives 8 weighted, 1 gives 0 weighted (all strict), and a code m from 2 to 7 gives 9−m weighted queues (indices 0..8−m), so code 7 leaves two weighted queues. No code gives exactly one weighted queue.
- R5: While any strict queue of a channel is eligible, no weighted queue of that channel is granted.
- R6: With all weighted queues backlogged, each weighted queue in turn, in ascending index order and wrapping around, receives as many consecutive grants as its weight. After reset the first weighted turn starts at queue 0.
- R7: A weighted queue with weight zero receives one grant per turn.
- R8: While a grant is held and not dequeued, writes to the mode or the weights leave the granted queue unchanged. The new setting applies from the next decision.
- R9: Channels schedule independently: one channel's flags, mode and dequeues do not change another channel's grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_valid | input | NCH*8 | Per-queue has-packet flags, channel c at bits [8c+7:8c] |
| q_close | input | NCH*8 | Per-queue close bits, same layout |
| mode_we | input | 1 | Mode write strobe |
| mode_ch | input | CW | Channel addressed by a mode write |
| mode_val | input | 3 | Mode code written |
| wt_we | input | 1 | Weight write strobe |
| wt_ch | input | CW | Channel addressed by a weight write |
| wt_q | input | 3 | Queue addressed by a weight write |
| wt_val | input | 16 | Weight value written |
| deq | input | NCH | Per-channel dequeue pulse that consumes the current grant |
| gnt_vld | output | NCH | Per-channel grant valid |
| gnt_q | output | NCH*3 | Per-channel granted queue index |

## Verification
The hardest state to reach is a decision boundary inside a weighted turn while the configuration is changing. That needs a grant held across mode and weight writes, and then a weighted cycle whose credits include zero weights. The bench walks all eight mode codes. For each code it first backlogs every queue, which makes strict precedence visible. It then backlogs only the weighted queues and dequeues on every cycle, so that long grant sequences can be compared with a credit model. Separate runs hold a grant without dequeuing while the mode is rewritten, and close queues one by one under a backlog.

// File: rtl/esch_pkg.sv
package esch_pkg;
   localparam int QN  = 8;
   localparam int QIW = 3;

   // number of weighted queues selected by a mode code
   function automatic logic [3:0] weighted_count(input logic [2:0] m);
      case (m)
         3'd0:    weighted_count = 4'd8;
         3'd1:    weighted_count = 4'd0;
         default: weighted_count = 4'd9 - {1'b0, m};
      endcase
   endfunction
endpackage

// File: rtl/esch_prio_pick.sv
module esch_prio_pick #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  req,
   output logic          vld,
   output logic [IW-1:0] idx
);
   always_comb begin
      vld = |req;
      idx = '0;
      for (int i = 0; i < N; i++)
         if (req[i]) idx = IW'(i);
   end
endmodule

// File: rtl/esch_wrr_pick.sv
module esch_wrr_pick #(
   parameter int N  = 8,
   parameter int IW = 3,
   parameter int WW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N-1:0]    req,
   input  logic [N*WW-1:0] wts,
   input  logic            take,
   output logic            vld,
   output logic [IW-1:0]   idx
);
   logic [IW-1:0] ptr;
   logic [WW-1:0] cred;
   logic          stay, nxt_v;
   logic [IW-1:0] nxt;
   logic [WW-1:0] wsel;

   always_comb begin
      stay  = req[ptr] && (cred != '0);
      nxt_v = 1'b0;
      nxt   = ptr;
      for (int k = N; k >= 1; k--) begin
         automatic int j = (int'(ptr) + k) % N;
         if (req[j]) begin
            nxt   = IW'(j);
            nxt_v = 1'b1;
         end
      end
      vld  = stay | nxt_v;
      idx  = stay ? ptr : nxt;
      wsel = wts[int'(nxt)*WW +: WW];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr  <= IW'(N-1);
         cred <= '0;
      end else if (take) begin
         if (stay) cred <= cred - 1'b1;
         else if (nxt_v) begin
            ptr  <= nxt;
            cred <= (wsel == '0) ? '0 : wsel - 1'b1;
         end
      end
   end
endmodule

// File: rtl/esch_chan.sv
module esch_chan
   import esch_pkg::*;
#(
   parameter int WW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2:0]      mode,
   input  logic [QN-1:0]   elig,
   input  logic [QN*WW-1:0] wts,
   input  logic            deq,
   output logic            gnt_vld,
   output logic [QIW-1:0]  gnt_q
);
   logic [3:0]     nw;
   logic [QN-1:0]  smask, s_req, w_req;
   logic           s_vld, w_vld, need, held_v;
   logic [QIW-1:0] s_idx, w_idx, held_q;

   always_comb begin
      nw = weighted_count(mode);
      for (int i = 0; i < QN; i++) smask[i] = (4'(i) >= nw);
      s_req = elig & smask;
      w_req = elig & ~smask;
   end

   esch_prio_pick #(.N(QN), .IW(QIW)) u_strict (
      .req(s_req), .vld(s_vld), .idx(s_idx));

   esch_wrr_pick #(.N(QN), .IW(QIW), .WW(WW)) u_wrr (
      .clk(clk), .rst_n(rst_n), .req(w_req), .wts(wts),
      .take(need && !s_vld), .vld(w_vld), .idx(w_idx));

   assign need = !held_v || deq || !elig[held_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_v <= 1'b0;
         held_q <= '0;
      end else if (need) begin
         held_v <= s_vld | w_vld;
         held_q <= s_vld ? s_idx : w_idx;
      end
   end

   assign gnt_vld = held_v && elig[held_q];
   assign gnt_q   = held_q;

   a_r3_only_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld |-> elig[gnt_q]);
   a_r8_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_vld && $past(gnt_vld && !deq)) |-> $stable(gnt_q));
   a_r2_top_strict: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_vld && $past(need && s_vld)) |-> (($past(s_req) >> gnt_q) == QN'(1)));
   a_r5_strict_first: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_vld && $past(need) && ({1'b0, gnt_q} < $past(nw))) |-> ($past(s_req) == '0));
endmodule

// File: rtl/esch_top.sv
module esch_top
   import esch_pkg::*;
#(
   parameter int NCH = 2,
   parameter int NQ  = 8,
   parameter int WW  = 16,
   localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH*NQ-1:0] q_valid,
   input  logic [NCH*NQ-1:0] q_close,
   input  logic              mode_we,
   input  logic [CW-1:0]     mode_ch,
   input  logic [2:0]        mode_val,
   input  logic              wt_we,
   input  logic [CW-1:0]     wt_ch,
   input  logic [2:0]        wt_q,
   input  logic [WW-1:0]     wt_val,
   input  logic [NCH-1:0]    deq,
   output logic [NCH-1:0]    gnt_vld,
   output logic [NCH*3-1:0]  gnt_q
);
   if (NQ != QN) begin : g_bad_nq
      initial $error("esch_top: NQ must be 8");
   end
   if (NCH < 1) begin : g_bad_nch
      initial $error("esch_top: NCH must be at least 1");
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [2:0]       md;
      logic [NQ*WW-1:0] wv;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            md <= 3'd1;
            wv <= '0;
         end else begin
            if (mode_we && (int'(mode_ch) == c)) md <= mode_val;
            if (wt_we && (int'(wt_ch) == c)) wv[int'(wt_q)*WW +: WW] <= wt_val;
         end
      end

      esch_chan #(.WW(WW)) u_chan (
         .clk(clk), .rst_n(rst_n), .mode(md),
         .elig(q_valid[c*NQ +: NQ] & ~q_close[c*NQ +: NQ]),
         .wts(wv), .deq(deq[c]),
         .gnt_vld(gnt_vld[c]), .gnt_q(gnt_q[c*3 +: 3]));
   end
endmodule

// File: tb/test_esch_top.sv
module test_esch_top;
   localparam int NCH = 2;
   logic clk = 0, rst_n = 0;
   logic [15:0] q_valid = '0, q_close = '0;
   logic mode_we = 0, wt_we = 0;
   logic mode_ch = 0, wt_ch = 0;
   logic [2:0] mode_val = '0, wt_q = '0;
   logic [15:0] wt_val = '0;
   logic [1:0] deq = '0;
   logic [1:0] gnt_vld;
   logic [5:0] gnt_q;
   int n_run = 0, n_fail = 0;

   always #10 clk = ~clk;

   esch_top #(.NCH(NCH)) i_esch_top (.*);

   task automatic chk(input string r, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
      end
   endtask

   task automatic do_reset();
      q_valid = '0; q_close = '0; deq = '0;
      rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
   endtask

   task automatic set_mode(input int ch, input int m);
      @(negedge clk); mode_we = 1; mode_ch = ch[0]; mode_val = 3'(m);
      @(negedge clk); mode_we = 0;
   endtask

   task automatic set_wt(input int ch, input int q, input int w);
      @(negedge clk); wt_we = 1; wt_ch = ch[0]; wt_q = 3'(q); wt_val = 16'(w);
      @(negedge clk); wt_we = 0;
   endtask

   function automatic int nweighted(input int m);
      return (m == 0) ? 8 : (m == 1) ? 0 : 9 - m;
   endfunction

   int gq0;
   assign gq0 = int'(gnt_q[2:0]);

   initial begin
      #3_000_000;
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      do_reset();
      chk("R1 no grant ch0", int'(gnt_vld[0]), 0);
      chk("R1 no grant ch1", int'(gnt_vld[1]), 0);
      // R1/R2: default all strict, highest index wins
      q_valid[7:0] = 8'hFF; q_valid[15:8] = 8'h08;
      @(negedge clk); @(negedge clk);
      chk("R2 default strict top", gq0, 7);
      chk("R9 ch1 own grant", int'(gnt_q[5:3]), 3);
      // R8: held grant survives config writes
      set_mode(0, 0);
      set_wt(0, 7, 5);
      chk("R8 held after writes vld", int'(gnt_vld[0]), 1);
      chk("R8 held after writes q", gq0, 7);
      deq[0] = 1; @(negedge clk); deq[0] = 0;
      chk("R8 next decision uses new mode", gq0, 0);
      chk("R9 ch1 unaffected", int'(gnt_q[5:3]), 3);

      // R3: closing queues under all-strict
      do_reset();
      q_valid[7:0] = 8'hFF; q_close[7:0] = 8'h80;
      @(negedge clk); @(negedge clk);
      chk("R3 closed top skipped", gq0, 6);
      for (int k = 6; k >= 0; k--) begin
         q_close[7:0] = q_close[7:0] | 8'(1 << k);
         @(negedge clk);
         chk("R3 closed not shown", int'(gnt_vld[0] && (gq0 >= k)), 0);
         @(negedge clk);
      end
      chk("R3 all closed no grant", int'(gnt_vld[0]), 0);
      q_close[7:0] = 8'h00;
      @(negedge clk); @(negedge clk);
      chk("R3 reopened", gq0, 7);

      // R4..R7: sweep all mode codes
      for (int m = 0; m < 8; m++) begin
         automatic int nw = nweighted(m);
         automatic int ptr = 7, cred = 0;
         automatic int w[8];
         do_reset();
         set_mode(0, m);
         for (int q = 0; q < 8; q++) begin
            w[q] = q % 4;
            set_wt(0, q, w[q]);
         end
         // scenario A: everything backlogged
         q_valid[7:0] = 8'hFF;
         @(negedge clk);
         for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            chk("R5 strict precedes weighted", gq0, (nw == 8) ? ((s == 0) ? 0 : gq0) : 7);
            if (nw < 8) chk("R4 top strict present", int'(gnt_vld[0]), 1);
            deq[0] = 1; @(negedge clk); deq[0] = 0;
         end
         // scenario B: only weighted queues backlogged, fresh state
         do_reset();
         set_mode(0, m);
         for (int q = 0; q < 8; q++) set_wt(0, q, w[q]);
         q_valid[7:0] = 8'((1 << nw) - 1);
         @(negedge clk);
         if (nw == 0) begin
            chk("R4 mode1 no weighted", int'(gnt_vld[0]), 0);
         end else begin
            for (int s = 0; s < 14; s++) begin
               automatic int exp;
               if (ptr < nw && cred > 0) begin
                  cred--; exp = ptr;
               end else begin
                  for (int k = 1; k <= 8; k++)
                     if (((ptr + k) % 8) < nw) begin
                        ptr = (ptr + k) % 8; break;
                     end
                  cred = (w[ptr] == 0) ? 0 : w[ptr] - 1;
                  exp = ptr;
               end
               chk("R6 R7 weighted sequence", int'(gnt_vld[0]) * 8 + gq0, 8 + exp);
               deq[0] = 1; @(negedge clk);
            end
            deq[0] = 0;
         end
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule